// File: doc/BRIEF.md
# Load Data Register Repacker

This block takes 64-bit load beats from the memory side and turns them into write operations for a set of register-file banks. A beat can hold one 64-bit element, two 32-bit elements or four 16-bit elements, packed next to each other in memory order. Beats can come back in any order. Each beat carries its own tag, and the tag gives the index of its first element, how many elements in the beat are valid, the element width and a byte offset. The offset gives the leading bytes to discard when the base address is not 64-bit aligned.

In register order, element `i` belongs to bank `i mod NB`. A bank row holds `64/width` elements, and the elements that share a row are `NB` indices apart. The block rotates the contiguous elements of a beat so that each one reaches its own bank in the same cycle. It computes the row and the lane for each element and places the element in that lane. A byte mask with each write leaves the other lanes of the row unchanged.

Each bank has a two-entry queue in front of it. A queue presents its head whenever it holds data and drops that head when the bank takes it. A beat is taken only when every bank it targets has room in its queue.

Top module: `ldr_repack`

## Requirements
- R1: After reset, every queue is empty: `bw_valid` is all zero and `resp_ready` is high.
- R2: Element `k` of an accepted beat (k = 0 .. cnt-1) is written to bank `(resp_start + k) mod NB`. The banks wrap past NB-1 back to bank 0.
- R3: For element index `idx` and density `d = 64/width`, the write row is `idx / (NB*d)` and the lane is `(idx / NB) mod d`. The element sits in bits `[lane*width +: width]` of `bw_data`, and `bw_mask` sets exactly the bytes of that lane.
- R4: `resp_ew` encodes the element width: 0 is 64-bit, 1 is 32-bit, 2 is 16-bit. Value 3 is reserved.
- R5: The first `resp_boff` bytes of the beat are discarded. Element `k` is taken from the bytes starting at byte `resp_boff + k*width/8`, with byte 0 at bits [7:0].
- R6: Only `resp_cnt` elements are written (0 to 4). Banks not targeted by the beat get no write, and a count of zero writes nothing.
- R7: `resp_ready` is low exactly when some bank targeted by the presented beat has a full queue. While it is low, no queue takes any data.
- R8: Each bank queue holds up to two entries and releases them in arrival order. A head that is not taken stays unchanged.
- R9: The writes for a beat accepted at a clock edge appear on `bw_valid` right after that edge, and not before it.
- R10: A full or stalled queue in one bank does not block beats that target only other banks, and it does not block the other queues from draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resp_valid | input | 1 | A load beat is presented |
| resp_ready | output | 1 | The beat is taken at this edge |
| resp_data | input | 64 | Beat payload, bytes in memory order |
| resp_start | input | IDX_W | Element index of the first element in the beat |
| resp_cnt | input | 3 | Number of valid elements (0 to 4) |
| resp_ew | input | 2 | Element width code |
| resp_boff | input | 3 | Leading bytes to discard |
| bw_valid | output | NB | Bank queue head is valid |
| bw_ready | input | NB | Bank takes its head this cycle |
| bw_row | output | NB*ROW_W | Row address per bank |
| bw_data | output | NB*64 | Row-aligned write data per bank |
| bw_mask | output | NB*8 | Byte write mask per bank |

## Verification
The bench sends beats whose elements wrap from the last bank back to bank 0. A design that rotates the wrong way, or without the modulo, would write those elements into the wrong banks. 16-bit beats at several start indices check the lane and row arithmetic, where a slip would put an element in the wrong quarter of a row or set the wrong mask bytes. Unaligned beats and partial counts show whether the leading bytes are dropped and whether any banks past the count receive stray writes. A directed test fills one queue while a second bank stays live. It checks that this queue's backpressure stops only the beats that target the full queue, that order is kept across two entries, and that the other bank drains on its own.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam int BEAT_W = 64;
  localparam int BEAT_B = BEAT_W / 8;

  typedef enum logic [1:0] {
    EW_64 = 2'd0,
    EW_32 = 2'd1,
    EW_16 = 2'd2,
    EW_RSV = 2'd3
  } ew_e;

  // bytes per element for a width code
  function automatic int f_elem_bytes(input ew_e ew);
    return BEAT_B >> int'(ew);
  endfunction

  // register row of element idx: one row covers nb*density elements
  function automatic int f_row(input int idx, input int nb_log, input ew_e ew);
    return idx >> (nb_log + int'(ew));
  endfunction

  // lane within the row: which slot of the packed row holds idx
  function automatic int f_lane(input int idx, input int nb_log, input ew_e ew);
    return (idx >> nb_log) & ((1 << int'(ew)) - 1);
  endfunction

  // take element k from a beat after discarding boff leading bytes
  function automatic logic [BEAT_W-1:0] f_pick(input logic [BEAT_W-1:0] beat,
                                               input int boff, input int k,
                                               input ew_e ew);
    logic [BEAT_W-1:0] sh;
    int pos;
    pos = boff + k * f_elem_bytes(ew);
    sh  = (pos >= BEAT_B) ? '0 : (beat >> (8 * pos));
    case (ew)
      EW_64:   return sh;
      EW_32:   return {32'd0, sh[31:0]};
      EW_16:   return {48'd0, sh[15:0]};
      default: return {56'd0, sh[7:0]};
    endcase
  endfunction

  // move an element into its lane of the row
  function automatic logic [BEAT_W-1:0] f_place(input logic [BEAT_W-1:0] elem,
                                                input int lane, input ew_e ew);
    return elem << (8 * lane * f_elem_bytes(ew));
  endfunction

  // byte mask of one lane
  function automatic logic [BEAT_B-1:0] f_mask(input int lane, input ew_e ew);
    logic [BEAT_B-1:0] one;
    one = BEAT_B'((1 << f_elem_bytes(ew)) - 1);
    return one << (lane * f_elem_bytes(ew));
  endfunction

endpackage

// File: rtl/ldr_rotate.sv
module ldr_rotate
  import ldr_pkg::*;
#(
  parameter int NB    = 8,
  parameter int IDX_W = 11,
  parameter int ROW_W = 8
) (
  input  logic [IDX_W-1:0]      start,
  input  logic [2:0]            cnt,
  input  ew_e                   ew,
  input  logic [2:0]            boff,
  input  logic [BEAT_W-1:0]     beat,
  output logic [NB-1:0]         hit,
  output logic [NB*ROW_W-1:0]   row,
  output logic [NB*BEAT_W-1:0]  wdata,
  output logic [NB*BEAT_B-1:0]  wmask
);
  localparam int BL = $clog2(NB);

  // rotation: bank b receives element k = (b - start) mod NB
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BL-1:0]     k;
    logic [IDX_W-1:0]  idx;
    logic [BEAT_W-1:0] elem;
    int                lane;

    assign k    = BL'(b) - start[BL-1:0];
    assign idx  = start + IDX_W'(k);
    assign lane = f_lane(int'(idx), BL, ew);
    assign elem = f_pick(beat, int'(boff), int'(k), ew);

    assign hit[b]                        = int'(k) < int'(cnt);
    assign row[b*ROW_W +: ROW_W]         = ROW_W'(f_row(int'(idx), BL, ew));
    assign wdata[b*BEAT_W +: BEAT_W]     = f_place(elem, lane, ew);
    assign wmask[b*BEAT_B +: BEAT_B]     = f_mask(lane, ew);
  end

endmodule

// File: rtl/ldr_bank_q.sv
module ldr_bank_q #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         vld,
  output logic         full,
  output logic [W-1:0] dout
);
  logic [W-1:0] slot0, slot1;
  logic [1:0]   n;
  logic         do_push, do_pop;

  assign do_pop  = pop && (n != 2'd0);
  assign do_push = push && ((n != 2'd2) || do_pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n     <= 2'd0;
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      case ({do_push, do_pop})
        2'b10: begin
          if (n == 2'd0) slot0 <= din;
          else           slot1 <= din;
          n <= n + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          n     <= n - 2'd1;
        end
        2'b11: begin
          if (n == 2'd1) slot0 <= din;
          else begin
            slot0 <= slot1;
            slot1 <= din;
          end
        end
        default: ;
      endcase
    end
  end

  assign vld  = (n != 2'd0);
  assign full = (n == 2'd2);
  assign dout = slot0;

endmodule

// File: rtl/ldr_repack.sv
module ldr_repack
  import ldr_pkg::*;
#(
  parameter int NB    = 8,
  parameter int IDX_W = 11,
  localparam int ROW_W = IDX_W - $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 resp_valid,
  output logic                 resp_ready,
  input  logic [63:0]          resp_data,
  input  logic [IDX_W-1:0]     resp_start,
  input  logic [2:0]           resp_cnt,
  input  logic [1:0]           resp_ew,
  input  logic [2:0]           resp_boff,
  output logic [NB-1:0]        bw_valid,
  input  logic [NB-1:0]        bw_ready,
  output logic [NB*ROW_W-1:0]  bw_row,
  output logic [NB*64-1:0]     bw_data,
  output logic [NB*8-1:0]      bw_mask
);
  localparam int EW = ROW_W + BEAT_W + BEAT_B;

  logic [NB-1:0]         tgt_hit;
  logic [NB*ROW_W-1:0]   rot_row;
  logic [NB*BEAT_W-1:0]  rot_data;
  logic [NB*BEAT_B-1:0]  rot_mask;
  logic [NB-1:0]         q_full, q_push, q_pop;
  logic                  accept;

  ldr_rotate #(.NB(NB), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_rot (
    .start (resp_start),
    .cnt   (resp_cnt),
    .ew    (ew_e'(resp_ew)),
    .boff  (resp_boff),
    .beat  (resp_data),
    .hit   (tgt_hit),
    .row   (rot_row),
    .wdata (rot_data),
    .wmask (rot_mask)
  );

  // all-or-nothing acceptance across the targeted banks
  assign resp_ready = ~|(tgt_hit & q_full);
  assign accept     = resp_valid && resp_ready;
  assign q_push     = accept ? tgt_hit : '0;
  assign q_pop      = bw_valid & bw_ready;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [EW-1:0] qin, qout;
    assign qin = {rot_row[b*ROW_W +: ROW_W],
                  rot_data[b*BEAT_W +: BEAT_W],
                  rot_mask[b*BEAT_B +: BEAT_B]};

    ldr_bank_q #(.W(EW)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (q_push[b]),
      .din  (qin),
      .pop  (q_pop[b]),
      .vld  (bw_valid[b]),
      .full (q_full[b]),
      .dout (qout)
    );

    assign bw_row[b*ROW_W +: ROW_W]   = qout[EW-1 -: ROW_W];
    assign bw_data[b*64 +: 64]        = qout[BEAT_B +: BEAT_W];
    assign bw_mask[b*8 +: 8]          = qout[BEAT_B-1:0];
  end

endmodule

// File: rtl/ldr_repack_chk.sv
module ldr_repack_chk #(
  parameter int NB = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           resp_valid,
  input logic           resp_ready,
  input logic [NB-1:0]  bw_valid,
  input logic [NB-1:0]  bw_ready,
  input logic [NB*64-1:0] bw_data,
  input logic [NB*8-1:0]  bw_mask,
  input logic [NB-1:0]  q_push,
  input logic [NB-1:0]  q_full,
  input logic [NB-1:0]  q_pop,
  input logic [NB-1:0]  tgt_hit
);

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bw_valid == '0) && resp_ready);

  p_blocked_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> (q_push == '0));

  p_push_targets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready) |-> (q_push == tgt_hit));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tgt_hit) <= 4);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push[b] && q_full[b]) |-> q_pop[b]);

    p_hold_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_valid[b] && !bw_ready[b]) |=>
        (bw_valid[b] && $stable(bw_data[b*64 +: 64]) && $stable(bw_mask[b*8 +: 8])));

    p_push_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
      q_push[b] |=> bw_valid[b]);

    p_mask_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bw_valid[b] |-> ($countones(bw_mask[b*8 +: 8]) == 2 ||
                       $countones(bw_mask[b*8 +: 8]) == 4 ||
                       $countones(bw_mask[b*8 +: 8]) == 8));
  end

endmodule

bind ldr_repack ldr_repack_chk #(.NB(NB)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready),
  .bw_valid  (bw_valid),
  .bw_ready  (bw_ready),
  .bw_data   (bw_data),
  .bw_mask   (bw_mask),
  .q_push    (q_push),
  .q_full    (q_full),
  .q_pop     (q_pop),
  .tgt_hit   (tgt_hit)
);

// File: tb/test_ldr_repack.sv
module test_ldr_repack;
  localparam int PERIOD = 10;
  localparam int NB     = 8;
  localparam int IDX_W  = 11;
  localparam int ROW_W  = IDX_W - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resp_valid = 1'b0;
  logic resp_ready;
  logic [63:0] resp_data = '0;
  logic [IDX_W-1:0] resp_start = '0;
  logic [2:0] resp_cnt = '0;
  logic [1:0] resp_ew = '0;
  logic [2:0] resp_boff = '0;
  logic [NB-1:0] bw_valid;
  logic [NB-1:0] bw_ready = '0;
  logic [NB*ROW_W-1:0] bw_row;
  logic [NB*64-1:0] bw_data;
  logic [NB*8-1:0] bw_mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ldr_repack #(.NB(NB), .IDX_W(IDX_W)) i_ldr_repack (
    .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_start(resp_start), .resp_cnt(resp_cnt),
    .resp_ew(resp_ew), .resp_boff(resp_boff), .bw_valid(bw_valid),
    .bw_ready(bw_ready), .bw_row(bw_row), .bw_data(bw_data), .bw_mask(bw_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference placement, written from the requirement text
  task automatic expect_bank(input int b, input int s, input int c, input int ew,
                             input int bo, input logic [63:0] d, output bit v,
                             output int row, output logic [63:0] dat,
                             output logic [7:0] m);
    int eb, dens, idx, lane;
    eb = (ew == 0) ? 8 : (ew == 1) ? 4 : 2;
    dens = 8 / eb;
    v = 0; row = 0; dat = '0; m = '0;
    for (int k = 0; k < c; k++) begin
      idx = s + k;
      if (idx % NB == b) begin
        v = 1;
        row = idx / (NB * dens);
        lane = (idx / NB) % dens;
        for (int j = 0; j < eb; j++) begin
          dat[8*(lane*eb+j) +: 8] = d[8*(bo+k*eb+j) +: 8];
          m[lane*eb+j] = 1'b1;
        end
      end
    end
  endtask

  task automatic drive(input int s, input int c, input int ew, input int bo,
                       input logic [63:0] d, output bit rdy);
    @(negedge clk);
    resp_valid = 1'b1; resp_start = IDX_W'(s); resp_cnt = 3'(c);
    resp_ew = 2'(ew); resp_boff = 3'(bo); resp_data = d;
    #1 rdy = resp_ready;
    @(posedge clk);
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  task automatic drain();
    bw_ready = '1;
    repeat (3) @(negedge clk);
    bw_ready = '0;
  endtask

  task automatic check_head(input string req, input int b, input bit v, input int row,
                            input logic [63:0] dat, input logic [7:0] m);
    chk(req, 64'(bw_valid[b]), 64'(v));
    if (v) begin
      chk(req, 64'(bw_row[b*ROW_W +: ROW_W]), 64'(row));
      chk(req, bw_data[b*64 +: 64], dat);
      chk(req, 64'(bw_mask[b*8 +: 8]), 64'(m));
    end
  endtask

  // one beat into empty queues: ready, timing and every bank's head
  task automatic run_single(input string req, input int s, input int c, input int ew,
                            input int bo, input logic [63:0] d);
    bit rdy, v;
    int row;
    logic [63:0] dat;
    logic [7:0] m;
    @(negedge clk);
    resp_valid = 1'b1; resp_start = IDX_W'(s); resp_cnt = 3'(c);
    resp_ew = 2'(ew); resp_boff = 3'(bo); resp_data = d;
    #1 rdy = resp_ready;
    chk({req, " R7 ready with room"}, 64'(rdy), 64'd1);
    chk({req, " R9 nothing before edge"}, 64'(bw_valid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    resp_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      expect_bank(b, s, c, ew, bo, d, v, row, dat, m);
      check_head(req, b, v, row, dat, m);
    end
    drain();
    chk({req, " R8 drained"}, 64'(bw_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 bw_valid after reset", 64'(bw_valid), 64'd0);
    chk("R1 resp_ready after reset", 64'(resp_ready), 64'd1);
  endtask

  task automatic t_double();
    run_single("R2 R3 R4 64-bit", 13, 1, 0, 0, 64'h8877_6655_4433_2211);
  endtask

  task automatic t_word_wrap();
    run_single("R2 R3 32-bit wrap", 7, 2, 1, 0, 64'hDEAD_BEEF_CAFE_F00D);
  endtask

  task automatic t_half_rot();
    run_single("R2 R3 16-bit rotate", 21, 4, 2, 0, 64'h8877_6655_4433_2211);
  endtask

  task automatic t_half_unal();
    run_single("R5 16-bit unaligned", 42, 3, 2, 2, 64'hA1B2_C3D4_E5F6_0718);
  endtask

  task automatic t_word_unal();
    run_single("R5 R6 32-bit unaligned", 9, 1, 1, 4, 64'h1357_9BDF_2468_ACE0);
  endtask

  task automatic t_partial();
    run_single("R6 16-bit partial", 60, 2, 2, 0, 64'h0F1E_2D3C_4B5A_6978);
  endtask

  task automatic t_empty();
    run_single("R6 zero count", 5, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_backpressure();
    bit rdy;
    bw_ready = '0;
    drive(3, 1, 0, 0, 64'h1111_1111_1111_1111, rdy);
    chk("R8 first entry taken", 64'(rdy), 64'd1);
    drive(11, 1, 0, 0, 64'h2222_2222_2222_2222, rdy);
    chk("R8 second entry taken", 64'(rdy), 64'd1);
    drive(19, 1, 0, 0, 64'h3333_3333_3333_3333, rdy);
    chk("R7 full bank blocks", 64'(rdy), 64'd0);
    check_head("R7 R8 head kept", 3, 1, 0, 64'h1111_1111_1111_1111, 8'hFF);
    drive(4, 1, 0, 0, 64'h4444_4444_4444_4444, rdy);
    chk("R10 other bank accepted", 64'(rdy), 64'd1);
    bw_ready = 8'h08;
    @(negedge clk);
    bw_ready = '0;
    check_head("R8 order", 3, 1, 1, 64'h2222_2222_2222_2222, 8'hFF);
    check_head("R10 bank4 untouched", 4, 1, 0, 64'h4444_4444_4444_4444, 8'hFF);
    drive(19, 1, 0, 0, 64'h3333_3333_3333_3333, rdy);
    chk("R7 accepted after pop", 64'(rdy), 64'd1);
    bw_ready = 8'h10;
    @(negedge clk);
    bw_ready = '0;
    chk("R10 bank4 drains alone", 64'(bw_valid[4]), 64'd0);
    bw_ready = 8'h08;
    @(negedge clk);
    bw_ready = '0;
    check_head("R8 third entry", 3, 1, 2, 64'h3333_3333_3333_3333, 8'hFF);
    drain();
    chk("R8 all drained", 64'(bw_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_double();
    t_word_wrap();
    t_half_rot();
    t_half_unal();
    t_word_unal();
    t_partial();
    t_empty();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule